// File: doc/BRIEF.md
# Power-Up Strap Capture and Glitch-Free Clock Stop Controller

This block decides when a group of already generated clocks are allowed to reach their loads. After reset it waits for the first falling edge of an active-low power-good input. It then waits a fixed number of reference-clock cycles and captures the strap pins into a held word. After a second fixed wait it lets the gated clocks run. A mode input removes power-good from the sequence. In that mode the sequence starts straight out of reset and power-good has no effect.

While the clocks run, each output follows its own enable bit and a shared active-low power-down input. Power-down is filtered in the CPU clock domain. Every gated output changes state only while its source is low, so no high phase is ever cut short, and an output restarts at the start of a full source period. The CPU output pair has its own gate. On power-down it either parks with the true side high and the complement low, or it releases both lines through an output-enable. A select input picks which.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While rst_ni is low, every clk_o bit is 0, strap_o is 0, cpu_t_o is 0, cpu_c_o is 1 and cpu_oe_o is 1.
- R2: With pg_mode_i=1, strap_o takes strap_i on the reference edge numbered WAIT_SAMPLE+3 after pwr_good_ni falls. That count is two synchronizer stages plus edge detection. Before that edge strap_o stays 0. Every clk_o bit stays 0 until reference edge WAIT_SAMPLE+WAIT_ENABLE+3.
- R3: Once the first falling edge of pwr_good_ni is consumed, later transitions of pwr_good_ni and changes of strap_i leave strap_o unchanged and do not stop the running clocks.
- R4: With pg_mode_i=1, pwr_good_ni held high starts no sequence and strap_o stays 0.
- R5: With pg_mode_i=0, pwr_good_ni is ignored. The sequence starts on the first reference edge after reset, and strap_o is captured on reference edge WAIT_SAMPLE+1.
- R6: out_en_i[g]=0 stops clk_o[g] low while the other outputs keep running. Setting the bit back to 1 restarts clk_o[g].
- R7: Every high phase of clk_o[g] lasts exactly one source high phase, and clk_o[g] rises only while src_clk_i[g] is high.
- R8: pd_ni takes effect only after it is seen low, past its synchronizer, on two consecutive clk_cpu_i rising edges. A low seen on a single edge has no effect on any output.
- R9: While power-down is in effect, every clk_o bit stops low. After release, all of them run again.
- R10: In power-down with cpu_hiz_i=0, cpu_t_o is held 1, cpu_c_o is held 0 and cpu_oe_o stays 1. A high phase of cpu_t_o is never shorter than a clk_cpu_i high phase.
- R11: In power-down with cpu_hiz_i=1, cpu_oe_o is 0. After release, cpu_oe_o returns to 1.
- R12: cpu_en_i=0 stops cpu_t_o at 0 and cpu_c_o at 1. cpu_c_o is always the complement of cpu_t_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock for the power-up sequencer |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_cpu_i | input | 1 | CPU source clock; also samples power-down |
| src_clk_i | input | N_OUT | Source clocks to be gated |
| out_en_i | input | N_OUT | Per-output run enables |
| cpu_en_i | input | 1 | Run enable of the CPU pair |
| cpu_hiz_i | input | 1 | CPU power-down stop select: 0 park high/low, 1 release lines |
| pd_ni | input | 1 | Active-low power-down request |
| pwr_good_ni | input | 1 | Active-low power-good |
| pg_mode_i | input | 1 | 1: sequence waits for power-good; 0: power-good ignored |
| strap_i | input | STRAP_W | Strap pins |
| clk_o | output | N_OUT | Gated clocks |
| cpu_t_o | output | 1 | CPU true clock |
| cpu_c_o | output | 1 | CPU complement clock |
| cpu_oe_o | output | 1 | CPU pair output enable |
| strap_o | output | STRAP_W | Captured strap word |

## Verification
The bench builds the block with N_OUT=3, STRAP_W=5, WAIT_SAMPLE=8 and WAIT_ENABLE=20. These small waits bring the exact capture and enable edges of both power-good modes into a few hundred reference cycles, so each edge can be checked against a cycle-counted model. The three sources have different half periods of 4, 7 and 11 ns against a 6 ns CPU clock. That spread lets stop and restart events land at many phase offsets, and every gated high phase is timed against its source.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SAMPLE = 2'd1,
    SEQ_SETTLE = 2'd2,
    SEQ_RUN    = 2'd3
  } seq_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= RST_VAL;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/strap_seq.sv
module strap_seq
  import clkgate_pkg::*;
#(
  parameter int STRAP_W     = 5,
  parameter int WAIT_SAMPLE = 3580,
  parameter int WAIT_ENABLE = 16408,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pg_mode_i,
  input  logic               pwr_good_ni,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [STRAP_W-1:0] strap_o,
  output logic               run_o
);
  localparam int CNT_MAX = max_int(WAIT_SAMPLE, WAIT_ENABLE);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LAST_SAMPLE = CNT_W'(WAIT_SAMPLE - 1);
  localparam logic [CNT_W-1:0] LAST_ENABLE = CNT_W'(WAIT_ENABLE - 1);

  seq_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [STRAP_W-1:0] strap_q;
  logic               pg_s, pg_d_q, used_q, start;

  cg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pg_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pwr_good_ni), .q_o(pg_s)
  );

  // first falling edge only; mode 0 starts straight from reset
  assign start = !used_q && (pg_mode_i ? (pg_d_q && !pg_s) : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      strap_q <= '0;
      pg_d_q  <= 1'b1;
      used_q  <= 1'b0;
    end else begin
      pg_d_q <= pg_s;
      unique case (state_q)
        SEQ_IDLE: if (start) begin
          used_q  <= 1'b1;
          cnt_q   <= '0;
          state_q <= SEQ_SAMPLE;
        end
        SEQ_SAMPLE: begin
          if (cnt_q == LAST_SAMPLE) begin
            strap_q <= strap_i;
            cnt_q   <= '0;
            state_q <= SEQ_SETTLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SEQ_SETTLE: begin
          if (cnt_q == LAST_ENABLE) state_q <= SEQ_RUN;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= SEQ_RUN;
      endcase
    end
  end

  assign strap_o = strap_q;
  assign run_o   = (state_q == SEQ_RUN);

  AST_RUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> run_o); // R3
  AST_STRAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_SETTLE || state_q == SEQ_RUN) |=> $stable(strap_q)); // R3
  AST_IDLE_NO_STRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_IDLE) |-> (strap_q == '0)); // R4
endmodule

// File: rtl/pd_filter.sv
module pd_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  output logic pd_act_o
);
  logic pd_s, prev_q, act_q;

  cg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pd_ni), .q_o(pd_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      act_q  <= 1'b0;
    end else begin
      prev_q <= pd_s;
      act_q  <= !pd_s && !prev_q;
    end
  end

  assign pd_act_o = act_q;

  AST_PD_TWO_EDGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> (!$past(pd_s, 1) && !$past(pd_s, 2))); // R8
endmodule

// File: rtl/gate_cell.sv
module gate_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_o
);
  logic req_s, gate_q;

  cg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(run_i), .q_o(req_s)
  );

  // updates on the falling edge: gate moves only while the source is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else gate_q <= req_s;
  end

  assign clk_o = clk_i & gate_q;

  AST_GATE_OPEN_REQ: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(gate_q) |-> $past(req_s)); // R7
endmodule

// File: rtl/cpu_pair_gate.sv
module cpu_pair_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic en_i,
  input  logic hiz_i,
  input  logic pd_act_i,
  output logic t_o,
  output logic c_o,
  output logic oe_o
);
  logic ok_s, hiz_s, run_req, hold_req;
  logic lo_gate_q, hi_hold_q, hz_q;

  cg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ok_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(run_i & en_i), .q_o(ok_s)
  );
  cg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_hiz_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hiz_i), .q_o(hiz_s)
  );

  assign run_req  = ok_s && !pd_act_i;
  assign hold_req = ok_s && pd_act_i && !hiz_s;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lo_gate_q <= 1'b0;
    else lo_gate_q <= run_req;
  end

  // high hold sets while clock is high, clears only after low gate reopened
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_hold_q <= 1'b0;
      hz_q      <= 1'b0;
    end else begin
      hi_hold_q <= hold_req || (hi_hold_q && !lo_gate_q && run_req);
      hz_q      <= pd_act_i && hiz_s;
    end
  end

  assign t_o  = (clk_i & lo_gate_q) | hi_hold_q;
  assign c_o  = !t_o;
  assign oe_o = !hz_q;

  AST_HOLD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hi_hold_q) |-> ($past(lo_gate_q) || !$past(run_req))); // R10
  AST_HIZ_IN_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> $past(pd_act_i)); // R11
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int N_OUT       = 4,
  parameter int STRAP_W     = 5,
  parameter int WAIT_SAMPLE = 3580,
  parameter int WAIT_ENABLE = 16408,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_ref_i,
  input  logic               rst_ni,
  input  logic               clk_cpu_i,
  input  logic [N_OUT-1:0]   src_clk_i,
  input  logic [N_OUT-1:0]   out_en_i,
  input  logic               cpu_en_i,
  input  logic               cpu_hiz_i,
  input  logic               pd_ni,
  input  logic               pwr_good_ni,
  input  logic               pg_mode_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [N_OUT-1:0]   clk_o,
  output logic               cpu_t_o,
  output logic               cpu_c_o,
  output logic               cpu_oe_o,
  output logic [STRAP_W-1:0] strap_o
);
  logic run, pd_act;

  strap_seq #(
    .STRAP_W(STRAP_W), .WAIT_SAMPLE(WAIT_SAMPLE),
    .WAIT_ENABLE(WAIT_ENABLE), .SYNC_STAGES(SYNC_STAGES)
  ) u_seq (
    .clk_i(clk_ref_i), .rst_ni(rst_ni), .pg_mode_i(pg_mode_i),
    .pwr_good_ni(pwr_good_ni), .strap_i(strap_i),
    .strap_o(strap_o), .run_o(run)
  );

  pd_filter #(.SYNC_STAGES(SYNC_STAGES)) u_pd (
    .clk_i(clk_cpu_i), .rst_ni(rst_ni), .pd_ni(pd_ni), .pd_act_o(pd_act)
  );

  generate
    for (genvar g = 0; g < N_OUT; g++) begin : g_out
      gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk_i(src_clk_i[g]), .rst_ni(rst_ni),
        .run_i(run & out_en_i[g] & !pd_act), .clk_o(clk_o[g])
      );
    end
  endgenerate

  cpu_pair_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cpu (
    .clk_i(clk_cpu_i), .rst_ni(rst_ni), .run_i(run), .en_i(cpu_en_i),
    .hiz_i(cpu_hiz_i), .pd_act_i(pd_act),
    .t_o(cpu_t_o), .c_o(cpu_c_o), .oe_o(cpu_oe_o)
  );

  AST_CPU_COMPLEMENT: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    cpu_c_o != cpu_t_o); // R12
  AST_NO_CLK_BEFORE_RUN: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (!run && $past(!run, 4)) |-> (clk_o == '0)); // R2
endmodule

// File: tb/clk_stop_ctrl_test.sv
`timescale 1ns/1ps
module clk_stop_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPU_HALF   = 3;
  localparam int N   = 3;
  localparam int SW  = 5;
  localparam int WS  = 8;
  localparam int WE  = 20;
  localparam int HALF [N] = '{4, 7, 11};

  logic clk_ref = 0, clk_cpu = 0, rst_ni = 0;
  logic [N-1:0] src = '0, out_en = '1;
  logic cpu_en = 1, cpu_hiz = 0, pd_ni = 1, pg_ni = 1, pg_mode = 1;
  logic [SW-1:0] strap = '0;
  logic [N-1:0] clk_o;
  logic cpu_t, cpu_c, cpu_oe;
  logic [SW-1:0] strap_o;

  int total = 0, bad = 0;
  int pulses [N];
  int cpu_pulses = 0;
  realtime rise_t [N];
  realtime cpu_rise = 0;
  int seq_cnt = 0;
  bit track = 0;
  int latch_at, run_at;
  logic [SW-1:0] exp_strap;

  clk_stop_ctrl #(.N_OUT(N), .STRAP_W(SW), .WAIT_SAMPLE(WS),
                  .WAIT_ENABLE(WE), .SYNC_STAGES(2)) uut (
    .clk_ref_i(clk_ref), .rst_ni(rst_ni), .clk_cpu_i(clk_cpu),
    .src_clk_i(src), .out_en_i(out_en), .cpu_en_i(cpu_en),
    .cpu_hiz_i(cpu_hiz), .pd_ni(pd_ni), .pwr_good_ni(pg_ni),
    .pg_mode_i(pg_mode), .strap_i(strap), .clk_o(clk_o),
    .cpu_t_o(cpu_t), .cpu_c_o(cpu_c), .cpu_oe_o(cpu_oe), .strap_o(strap_o)
  );

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;
  always #(CPU_HALF) clk_cpu = ~clk_cpu;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  for (genvar g = 0; g < N; g++) begin : g_mon
    always #(HALF[g]) src[g] = ~src[g];
    always @(posedge clk_o[g]) begin
      rise_t[g] = $realtime;
      chk(src[g] === 1'b1, "R7 rise inside source high", int'(src[g]), 1);
    end
    always @(negedge clk_o[g]) if (rst_ni) begin
      pulses[g]++;
      chk(int'($realtime - rise_t[g]) == HALF[g], "R7 high width",
          int'($realtime - rise_t[g]), HALF[g]);
    end
  end

  always @(posedge cpu_t) cpu_rise = $realtime;
  always @(negedge cpu_t) if (rst_ni) begin
    cpu_pulses++;
    chk(($realtime - cpu_rise) >= CPU_HALF, "R10 cpu high width",
        int'($realtime - cpu_rise), CPU_HALF);
  end

  // reference model of the power-up sequence, compared every reference clock
  always @(posedge clk_ref) if (track) seq_cnt++;
  always @(negedge clk_ref) if (track) begin
    chk(strap_o == ((seq_cnt >= latch_at) ? exp_strap : '0),
        (pg_mode ? "R2 strap capture edge" : "R5 strap capture edge"),
        int'(strap_o), int'((seq_cnt >= latch_at) ? exp_strap : '0));
    if (seq_cnt < run_at)
      chk(clk_o == '0, "R2 outputs held before enable", int'(clk_o), 0);
    if (seq_cnt > run_at + 10) track = 0;
  end

  task automatic snap(output int s [N], output int cs);
    for (int g = 0; g < N; g++) s[g] = pulses[g];
    cs = cpu_pulses;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a [N];
    int b [N];
    int ca, cb;
    for (int g = 0; g < N; g++) pulses[g] = 0;
    #23;
    // R1 reset state
    chk(clk_o == '0, "R1 clk_o in reset", int'(clk_o), 0);
    chk(strap_o == '0, "R1 strap_o in reset", int'(strap_o), 0);
    chk(cpu_t == 0 && cpu_c == 1, "R1 cpu pair in reset", int'({cpu_t, cpu_c}), 1);
    chk(cpu_oe == 1, "R1 cpu oe in reset", int'(cpu_oe), 1);

    strap = 5'h15;
    @(negedge clk_ref) rst_ni = 1;
    // R4 no sequence while power-good stays high
    repeat (WS + WE + 10) @(negedge clk_ref);
    chk(strap_o == '0, "R4 no capture without power-good edge", int'(strap_o), 0);
    chk(clk_o == '0, "R4 outputs idle without power-good edge", int'(clk_o), 0);

    // R2 capture and enable timing
    @(negedge clk_ref);
    pg_ni = 0; exp_strap = 5'h15; latch_at = WS + 3; run_at = WS + WE + 3;
    seq_cnt = 0; track = 1;
    wait (track == 0);
    repeat (20) @(negedge clk_ref);
    snap(a, ca);
    repeat (30) @(negedge clk_ref);
    snap(b, cb);
    for (int g = 0; g < N; g++)
      chk(b[g] > a[g], "R2 outputs running after enable", b[g] - a[g], 1);
    chk(cb > ca, "R2 cpu running after enable", cb - ca, 1);

    // R3 later power-good transitions ignored
    strap = 5'h0A;
    pg_ni = 1; repeat (8) @(negedge clk_ref);
    pg_ni = 0; repeat (WS + WE + 10) @(negedge clk_ref);
    chk(strap_o == 5'h15, "R3 strap word held", int'(strap_o), 5'h15);
    snap(a, ca); repeat (20) @(negedge clk_ref); snap(b, cb);
    for (int g = 0; g < N; g++)
      chk(b[g] > a[g], "R3 outputs keep running", b[g] - a[g], 1);

    // R6 per-output enable
    out_en[1] = 0;
    repeat (10) @(negedge clk_ref);
    snap(a, ca); repeat (20) @(negedge clk_ref); snap(b, cb);
    chk(b[1] == a[1], "R6 disabled output stopped", b[1] - a[1], 0);
    chk(clk_o[1] == 0, "R6 disabled output low", int'(clk_o[1]), 0);
    chk(b[0] > a[0] && b[2] > a[2], "R6 other outputs running", b[0] - a[0], 1);
    out_en[1] = 1;
    repeat (10) @(negedge clk_ref);
    snap(a, ca); repeat (20) @(negedge clk_ref); snap(b, cb);
    chk(b[1] > a[1], "R6 output restarts", b[1] - a[1], 1);

    // R8 single-edge power-down low ignored
    @(posedge clk_cpu); #1 pd_ni = 0;
    @(posedge clk_cpu); #1 pd_ni = 1;
    snap(a, ca); repeat (20) @(negedge clk_ref); snap(b, cb);
    for (int g = 0; g < N; g++)
      chk(b[g] > a[g], "R8 single low sample ignored", b[g] - a[g], 1);
    chk(cb > ca, "R8 cpu unaffected by single low", cb - ca, 1);

    // R9/R10 power-down with park high
    cpu_hiz = 0;
    pd_ni = 0;
    repeat (10) @(negedge clk_ref);
    snap(a, ca); repeat (20) @(negedge clk_ref); snap(b, cb);
    for (int g = 0; g < N; g++)
      chk(b[g] == a[g], "R9 output stopped in power-down", b[g] - a[g], 0);
    chk(clk_o == '0, "R9 outputs low in power-down", int'(clk_o), 0);
    chk(cpu_t == 1 && cpu_c == 0, "R10 cpu parked true high", int'({cpu_t, cpu_c}), 2);
    chk(cpu_oe == 1, "R10 cpu oe kept", int'(cpu_oe), 1);
    chk(cb == ca, "R10 cpu stopped", cb - ca, 0);
    pd_ni = 1;
    repeat (10) @(negedge clk_ref);
    snap(a, ca); repeat (20) @(negedge clk_ref); snap(b, cb);
    for (int g = 0; g < N; g++)
      chk(b[g] > a[g], "R9 outputs resume", b[g] - a[g], 1);
    chk(cb > ca, "R10 cpu resumes", cb - ca, 1);

    // R11 power-down with released lines
    cpu_hiz = 1;
    repeat (3) @(negedge clk_ref);
    pd_ni = 0;
    repeat (10) @(negedge clk_ref);
    chk(cpu_oe == 0, "R11 cpu oe off in power-down", int'(cpu_oe), 0);
    pd_ni = 1;
    repeat (10) @(negedge clk_ref);
    chk(cpu_oe == 1, "R11 cpu oe back after release", int'(cpu_oe), 1);
    cpu_hiz = 0;

    // R12 cpu enable
    cpu_en = 0;
    repeat (10) @(negedge clk_ref);
    snap(a, ca); repeat (10) @(negedge clk_ref); snap(b, cb);
    chk(cb == ca && cpu_t == 0 && cpu_c == 1, "R12 cpu disabled low/high",
        int'({cpu_t, cpu_c}), 1);
    cpu_en = 1;

    // R5 mode without power-good
    rst_ni = 0; pg_mode = 0; strap = 5'h0C; pg_ni = 1;
    repeat (3) @(negedge clk_ref);
    exp_strap = 5'h0C; latch_at = WS + 1; run_at = WS + WE + 1;
    seq_cnt = 0; track = 1; rst_ni = 1;
    fork
      begin repeat (6) begin #13 pg_ni = ~pg_ni; end end
      wait (track == 0);
    join
    chk(strap_o == 5'h0C, "R5 strap captured without power-good", int'(strap_o), 5'h0C);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule